// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central issue controller for a datapath that issues instructions in program order but lets them finish out of order on several independent functional units. There is no register renaming. Each decoded instruction names a target unit, one destination register and two source registers. The controller decides three things: whether the instruction may enter its unit, when that unit may fetch its operands from the register file, and when it may write its result back.

Each unit moves through four phases: issue, operand read, execute and result write. The controller keeps one slot per unit. A slot holds the unit's destination, its two sources, the unit that produces each source and a ready flag for each source. A separate table records which unit will write each register. Issue waits when the target unit is occupied or when the destination already has a pending writer. Operand read waits until both sources are free of pending writers. A finished unit holds its write while any earlier instruction still has to read the old value of the register it targets.

The register file and the units sit outside the block. A unit is told to read its operands by a one-cycle strobe. It signals the end of execution with a one-cycle done pulse and is told to commit its result by a one-cycle write strobe.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, no read or write strobe is active and an issue request to any unit is not stalled.
- R2: An issue request to a unit stalls from the cycle after that unit accepted an instruction through the cycle of its write strobe. The same request is accepted in the following cycle. A stalled request changes no state.
- R3: An issue request whose destination register has a pending writer stalls. Once that writer's write strobe has occurred, the same destination is accepted in the next cycle.
- R4: An accepted instruction whose sources have no pending writer raises its unit's read strobe exactly once, in the cycle after issue. Bit i of rd_en_o and wr_en_o corresponds to unit i.
- R5: An instruction whose source has a pending writer raises its read strobe in the cycle after that writer's write strobe, and not before.
- R6: A unit that has finished withholds its write strobe while an earlier-issued unit that has not yet read its operands still needs that unit's destination register. The write strobe follows in the cycle after that reader's read strobe.
- R7: A unit's write strobe rises in the cycle after its done pulse when no hazard or contention applies. A done pulse is ignored while the unit is not executing, including during its read cycle.
- R8: At most one write strobe is active per cycle. When several units may write, the lowest-numbered unit goes first and the others follow in later cycles.
- R9: An instruction issued in the same cycle as the write strobe of its source's producer treats that source as ready and raises its read strobe in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| iss_valid_i | input | 1 | A decoded instruction is offered for issue |
| iss_fu_i | input | log2(NUM_FU) | Target functional unit |
| iss_dst_i | input | log2(NUM_REG) | Destination register |
| iss_src_j_i | input | log2(NUM_REG) | First source register |
| iss_src_k_i | input | log2(NUM_REG) | Second source register |
| fu_done_i | input | NUM_FU | One-cycle end-of-execution pulse per unit |
| iss_stall_o | output | 1 | Offered instruction cannot issue this cycle |
| rd_en_o | output | NUM_FU | Per-unit operand read strobe |
| wr_en_o | output | NUM_FU | Per-unit result write strobe |

## Verification
If a slot records a stale producer or ready flag, a read strobe goes missing or comes early. This shows on rd_en_o in the cycle where the dependence should resolve, one cycle after the producer's write strobe. A register table that is not cleared or not set shows on iss_stall_o for the next instruction that targets that register. A wrong WAR decision moves a write strobe by one or more cycles relative to the reader's strobe. Every strobe is therefore checked against the exact cycle derived from the issue and done pattern, and a strobe in any cycle that is not expected counts as a failure.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_EXEC = 2'd2,
    ST_DONE = 2'd3
  } stage_e;
endpackage

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8,
  localparam int FU_W   = $clog2(NUM_FU),
  localparam int REG_W  = $clog2(NUM_REG)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            set_i,
  input  logic [REG_W-1:0]                set_reg_i,
  input  logic [FU_W-1:0]                 set_fu_i,
  input  logic                            clr_i,
  input  logic [REG_W-1:0]                clr_reg_i,
  output logic [NUM_REG-1:0]              pend_o,
  output logic [NUM_REG-1:0][FU_W-1:0]    owner_o
);
  logic [NUM_REG-1:0]           pend_q;
  logic [NUM_REG-1:0][FU_W-1:0] own_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      own_q  <= '0;
    end else begin
      if (clr_i) pend_q[clr_reg_i] <= 1'b0;
      if (set_i) begin
        pend_q[set_reg_i] <= 1'b1;
        own_q[set_reg_i]  <= set_fu_i;
      end
    end
  end

  assign pend_o  = pend_q;
  assign owner_o = own_q;

  // WAW stall must keep a second writer off a pending register
  assert_set_free_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> !pend_q[set_reg_i]);
  assert_clr_pending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> pend_q[clr_reg_i]);
endmodule

// File: rtl/sb_fu_slot.sv
module sb_fu_slot
  import sb_pkg::*;
#(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8,
  localparam int FU_W   = $clog2(NUM_FU),
  localparam int REG_W  = $clog2(NUM_REG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic [REG_W-1:0]  src_j_i,
  input  logic [REG_W-1:0]  src_k_i,
  input  logic [FU_W-1:0]   q_j_i,
  input  logic [FU_W-1:0]   q_k_i,
  input  logic              rdy_j_i,
  input  logic              rdy_k_i,
  input  logic              done_i,
  input  logic [NUM_FU-1:0] bcast_i,
  input  logic              gnt_i,
  output stage_e            stage_o,
  output logic [REG_W-1:0]  fi_o,
  output logic [REG_W-1:0]  fj_o,
  output logic [REG_W-1:0]  fk_o,
  output logic              rj_o,
  output logic              rk_o,
  output logic              rd_en_o
);
  stage_e           stage_q;
  logic [REG_W-1:0] fi_q, fj_q, fk_q;
  logic [FU_W-1:0]  qj_q, qk_q;
  logic             rj_q, rk_q;

  assign rd_en_o = (stage_q == ST_READ) && rj_q && rk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= ST_IDLE;
      fi_q <= '0; fj_q <= '0; fk_q <= '0;
      qj_q <= '0; qk_q <= '0;
      rj_q <= 1'b0; rk_q <= 1'b0;
    end else if (alloc_i) begin
      stage_q <= ST_READ;
      fi_q <= dst_i; fj_q <= src_j_i; fk_q <= src_k_i;
      qj_q <= q_j_i; qk_q <= q_k_i;
      rj_q <= rdy_j_i; rk_q <= rdy_k_i;
    end else begin
      unique case (stage_q)
        ST_READ: begin
          if (rd_en_o) begin
            stage_q <= ST_EXEC;
            rj_q <= 1'b0;
            rk_q <= 1'b0;
          end else begin
            // pick up the producer's result broadcast
            if (!rj_q && bcast_i[qj_q]) rj_q <= 1'b1;
            if (!rk_q && bcast_i[qk_q]) rk_q <= 1'b1;
          end
        end
        ST_EXEC: if (done_i) stage_q <= ST_DONE;
        ST_DONE: if (gnt_i)  stage_q <= ST_IDLE;
        default: ;
      endcase
    end
  end

  assign stage_o = stage_q;
  assign fi_o = fi_q;
  assign fj_o = fj_q;
  assign fk_o = fk_q;
  assign rj_o = rj_q;
  assign rk_o = rk_q;

  assert_single_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rd_en_o);
  assert_grant_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_i |-> stage_q == ST_DONE);
  assert_alloc_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> stage_q == ST_IDLE);
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
  parameter int NUM_FU = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_FU-1:0] req_i,
  output logic [NUM_FU-1:0] gnt_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = NUM_FU - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_o = NUM_FU'(1) << i;
    end
  end

  assert_wr_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  assert_gnt_in_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> (gnt_o != '0));
endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8,
  localparam int FU_W   = $clog2(NUM_FU),
  localparam int REG_W  = $clog2(NUM_REG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_valid_i,
  input  logic [FU_W-1:0]   iss_fu_i,
  input  logic [REG_W-1:0]  iss_dst_i,
  input  logic [REG_W-1:0]  iss_src_j_i,
  input  logic [REG_W-1:0]  iss_src_k_i,
  input  logic [NUM_FU-1:0] fu_done_i,
  output logic              iss_stall_o,
  output logic [NUM_FU-1:0] rd_en_o,
  output logic [NUM_FU-1:0] wr_en_o
);
  stage_e                       stage_v [NUM_FU];
  logic [NUM_FU-1:0][REG_W-1:0] fi_v, fj_v, fk_v;
  logic [NUM_FU-1:0]            rj_v, rk_v, busy_v, war_v, req_v;
  logic [NUM_REG-1:0]           pend;
  logic [NUM_REG-1:0][FU_W-1:0] owner;
  logic                         iss_fire, rdy_j, rdy_k, clr;
  logic [REG_W-1:0]             clr_reg;

  assign iss_stall_o = iss_valid_i && (busy_v[iss_fu_i] || pend[iss_dst_i]);
  assign iss_fire    = iss_valid_i && !iss_stall_o;

  // a producer committing this very cycle counts as already written
  assign rdy_j = !pend[iss_src_j_i] || wr_en_o[owner[iss_src_j_i]];
  assign rdy_k = !pend[iss_src_k_i] || wr_en_o[owner[iss_src_k_i]];

  for (genvar u = 0; u < NUM_FU; u++) begin : g_slot
    sb_fu_slot #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .alloc_i (iss_fire && (iss_fu_i == FU_W'(u))),
      .dst_i   (iss_dst_i),
      .src_j_i (iss_src_j_i),
      .src_k_i (iss_src_k_i),
      .q_j_i   (owner[iss_src_j_i]),
      .q_k_i   (owner[iss_src_k_i]),
      .rdy_j_i (rdy_j),
      .rdy_k_i (rdy_k),
      .done_i  (fu_done_i[u]),
      .bcast_i (wr_en_o),
      .gnt_i   (wr_en_o[u]),
      .stage_o (stage_v[u]),
      .fi_o    (fi_v[u]),
      .fj_o    (fj_v[u]),
      .fk_o    (fk_v[u]),
      .rj_o    (rj_v[u]),
      .rk_o    (rk_v[u]),
      .rd_en_o (rd_en_o[u])
    );
    assign busy_v[u] = stage_v[u] != ST_IDLE;
  end

  // WAR: a finished unit waits while an unread source still names its target
  always_comb begin
    for (int u = 0; u < NUM_FU; u++) begin
      war_v[u] = 1'b0;
      for (int v = 0; v < NUM_FU; v++) begin
        if (stage_v[v] == ST_READ &&
            ((fj_v[v] == fi_v[u] && rj_v[v]) || (fk_v[v] == fi_v[u] && rk_v[v])))
          war_v[u] = 1'b1;
      end
      req_v[u] = (stage_v[u] == ST_DONE) && !war_v[u];
    end
  end

  sb_wb_arb #(.NUM_FU(NUM_FU)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_v),
    .gnt_o  (wr_en_o)
  );

  always_comb begin
    clr_reg = '0;
    for (int u = 0; u < NUM_FU; u++) begin
      if (wr_en_o[u]) clr_reg = clr_reg | fi_v[u];
    end
  end
  assign clr = |wr_en_o;

  sb_reg_status #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (iss_fire),
    .set_reg_i (iss_dst_i),
    .set_fu_i  (iss_fu_i),
    .clr_i     (clr),
    .clr_reg_i (clr_reg),
    .pend_o    (pend),
    .owner_o   (owner)
  );

  assert_issue_binds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_i && !iss_stall_o) |=> busy_v[$past(iss_fu_i)]);
  assert_issue_marks_dst_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_i && !iss_stall_o) |=> pend[$past(iss_dst_i)]);
endmodule

// File: tb/sim_sb_hazard_ctrl.sv
module sim_sb_hazard_ctrl;
  typedef struct {
    int         cyc;
    logic [3:0] rd;
    logic [3:0] wr;
    bit         chk_st;
    logic       st;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iss_valid = 1'b0;
  logic [1:0] iss_fu = '0;
  logic [2:0] iss_dst = '0, iss_sj = '0, iss_sk = '0;
  logic [3:0] done = '0;
  logic       stall;
  logic [3:0] rd_en, wr_en;

  int   cyc = 0;
  int   tests = 0, fails = 0;
  bit   started = 0, finished = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  sb_hazard_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .iss_valid_i(iss_valid), .iss_fu_i(iss_fu),
    .iss_dst_i(iss_dst), .iss_src_j_i(iss_sj), .iss_src_k_i(iss_sk),
    .fu_done_i(done), .iss_stall_o(stall), .rd_en_o(rd_en), .wr_en_o(wr_en)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic tick();
    @(posedge clk); #1;
    iss_valid = 1'b0;
    done = '0;
  endtask

  task automatic issue(input int fu, input int dst, input int sj, input int sk);
    iss_valid = 1'b1;
    iss_fu = 2'(fu); iss_dst = 3'(dst); iss_sj = 3'(sj); iss_sk = 3'(sk);
  endtask

  task automatic push(input int c, input logic [3:0] rd, input logic [3:0] wr,
                      input bit chk_st, input logic st, input string tag);
    exp_t e;
    e.cyc = c; e.rd = rd; e.wr = wr; e.chk_st = chk_st; e.st = st; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
    end
  endtask

  // monitor: pops the expected item for this cycle, else demands silent strobes
  always @(negedge clk) begin
    if (rst_n && started && !finished) begin
      if (q.size() > 0 && q[0].cyc == cyc) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "rd_en", int'(rd_en), int'(e.rd));
        check(e.tag, "wr_en", int'(wr_en), int'(e.wr));
        if (e.chk_st) check(e.tag, "stall", int'(stall), int'(e.st));
      end else begin
        check("R4 R7", "idle rd_en", int'(rd_en), 0);
        check("R4 R7", "idle wr_en", int'(wr_en), 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int b;
    // R1: reset state
    issue(0, 1, 2, 3);
    @(negedge clk); @(negedge clk);
    check("R1", "stall in reset", int'(stall), 0);
    check("R1", "rd_en in reset", int'(rd_en), 0);
    check("R1", "wr_en in reset", int'(wr_en), 0);
    iss_valid = 1'b0;
    rst_n = 1'b1;
    tick();
    issue(0, 1, 2, 3);
    #2;
    check("R1", "stall after reset", int'(stall), 0);
    iss_valid = 1'b0;
    started = 1;
    tick();

    // Scenario A: structural stall, done ignored outside execute (R2, R4, R7)
    b = cyc;
    push(b+0, 4'b0000, 4'b0000, 1, 1'b0, "R2");
    push(b+1, 4'b0001, 4'b0000, 0, 1'b0, "R4");
    push(b+2, 4'b0000, 4'b0000, 1, 1'b1, "R2");
    push(b+4, 4'b0000, 4'b0001, 1, 1'b1, "R7");
    push(b+5, 4'b0000, 4'b0000, 1, 1'b0, "R2");
    push(b+6, 4'b0001, 4'b0000, 0, 1'b0, "R4");
    push(b+8, 4'b0000, 4'b0001, 0, 1'b0, "R7");
    issue(0, 1, 2, 3); tick();
    done = 4'b0001;    tick();
    issue(0, 4, 5, 6); tick();
    done = 4'b0001;    tick();
    issue(0, 4, 5, 6); tick();
    issue(0, 4, 5, 6); tick();
    tick();
    done = 4'b0001;    tick();
    tick(); tick();

    // Scenario B: WAW stall, RAW wait, write priority (R3, R5, R8)
    b = cyc;
    push(b+0, 4'b0000, 4'b0000, 1, 1'b0, "R3");
    push(b+1, 4'b0010, 4'b0000, 1, 1'b1, "R3");
    push(b+2, 4'b0000, 4'b0000, 1, 1'b0, "R5");
    push(b+4, 4'b0000, 4'b0010, 0, 1'b0, "R5");
    push(b+5, 4'b0100, 4'b0000, 1, 1'b0, "R5");
    push(b+6, 4'b1000, 4'b0000, 0, 1'b0, "R4");
    push(b+8, 4'b0000, 4'b0100, 0, 1'b0, "R8");
    push(b+9, 4'b0000, 4'b1000, 0, 1'b0, "R8");
    issue(1, 2, 0, 0); tick();
    issue(2, 2, 0, 0); tick();
    issue(2, 3, 2, 0); tick();
    done = 4'b0010;    tick();
    tick();
    issue(3, 2, 0, 0); tick();
    tick();
    done = 4'b1100;    tick();
    tick(); tick(); tick();

    // Scenario C: WAR hold of a finished unit (R6)
    b = cyc;
    push(b+0, 4'b0000, 4'b0000, 1, 1'b0, "R6");
    push(b+1, 4'b0001, 4'b0000, 1, 1'b0, "R6");
    push(b+2, 4'b0000, 4'b0000, 1, 1'b0, "R6");
    push(b+3, 4'b0100, 4'b0000, 0, 1'b0, "R4");
    push(b+6, 4'b0000, 4'b0001, 0, 1'b0, "R6");
    push(b+7, 4'b0010, 4'b0000, 0, 1'b0, "R5");
    push(b+8, 4'b0000, 4'b0100, 0, 1'b0, "R6");
    push(b+9, 4'b0000, 4'b0010, 0, 1'b0, "R7");
    issue(0, 5, 1, 1); tick();
    issue(1, 6, 5, 7); tick();
    issue(2, 7, 0, 0); tick();
    tick();
    done = 4'b0100;    tick();
    done = 4'b0001;    tick();
    tick(); tick();
    done = 4'b0010;    tick();
    tick(); tick();

    // Scenario D: issue in the producer's write cycle (R9)
    b = cyc;
    push(b+0, 4'b0000, 4'b0000, 1, 1'b0, "R9");
    push(b+1, 4'b1000, 4'b0000, 0, 1'b0, "R4");
    push(b+3, 4'b0000, 4'b1000, 1, 1'b0, "R9");
    push(b+4, 4'b0001, 4'b0000, 0, 1'b0, "R9");
    push(b+6, 4'b0000, 4'b0001, 0, 1'b0, "R7");
    issue(3, 4, 0, 0); tick();
    tick();
    done = 4'b1000;    tick();
    issue(0, 1, 4, 4); tick();
    tick();
    done = 4'b0001;    tick();
    tick(); tick(); tick();

    check("R4", "unconsumed expectations", q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule